// File: doc/BRIEF.md
# Event-Action PWM Generator

This block produces two pulse-width-modulated outputs from one 16-bit counter. The counter runs in one of two modes. In down-only mode it counts down and jumps back to a programmed period value. In up/down mode it climbs from zero to the period value and then falls back to zero. Two 16-bit compare values are checked against the counter on every cycle. A compare match counts as a separate event for each counting direction. Together with "count is zero" and "count equals the period value", this gives six counter events.

Each output has its own 12-bit action word. The word holds one 2-bit code per event and says whether that event leaves the output alone, inverts it, clears it or sets it. When several events land on the same cycle, a fixed priority picks the one that acts.

Every event also sets a sticky raw status bit, which is cleared by a strobed clear mask. A per-event mask forms a single interrupt line, and a second per-event mask forms a one-cycle trigger pulse for a converter or other downstream logic. New period and compare values take effect only when the count is at zero, so a period never ends partway through.

Top module: `pwm_evt_gen`

## Requirements
- R1: While `rst_n` is low, `count`, `pwm_a`, `pwm_b`, `raw_stat`, `irq` and `trig` are all zero.
- R2: Down-only mode (`updown`=0) with `run`=1:
  - when `count` is nonzero, the next value is `count`-1;
  - when `count` is zero, the next value is the `load_val` present on that cycle.
  - With `run`=0 the count holds its value in either mode.
- R3: Up/down mode (`updown`=1) with `run`=1:
  - the count steps by one, up from 0 to the active period value and then down to 0;
  - at 0 it reloads and starts upward again, or stays at 0 if the new period value is 0.
- R4: `load_val`, `cmpa_val` and `cmpb_val` are sampled into the active copies only on a running cycle where `count` is 0. A change at any other time does not alter the current period.
- R5: The six events, with bit index, are:
  - zero (0): `count`==0;
  - load (1): `count` equals the active period value and is nonzero;
  - A-up (2) and A-down (3): `count` equals the active A value;
  - B-up (4) and B-down (5): `count` equals the active B value.
  - The direction is up only if the last step was an increment. The count at zero and a freshly reloaded count in down-only mode both count as down.
- R6: Action word bits [2i+1:2i] hold the code for event i: 00 keep, 01 invert, 10 drive 0, 11 drive 1. The output changes on the clock edge that ends the event's cycle.
- R7: When several events coincide, only the first one in the order B-down, A-down, B-up, A-up, load, zero whose code is not 00 acts on a given output.
- R8: `raw_stat[i]` is set by event i whatever the enables. On a cycle with `clr_stb`=1, each bit set in `clr_mask` is cleared, unless the same event occurs on that cycle, in which case the bit stays set.
- R9: `irq` is high exactly when some `raw_stat[i]` and `irq_en[i]` are both 1.
- R10: `trig` is high for the one cycle after a cycle in which some event i occurs with `trg_en[i]`=1.
- R11: With `run`=0 no event occurs, so `pwm_a`, `pwm_b`, `raw_stat` (apart from clears) and `trig` do not react.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter advance and event enable |
| updown | input | 1 | 1 selects up/down counting, 0 down-only |
| load_val | input | 16 | Period value, taken at count zero |
| cmpa_val | input | 16 | Compare A value, taken at count zero |
| cmpb_val | input | 16 | Compare B value, taken at count zero |
| act_a | input | 12 | Action word for output A |
| act_b | input | 12 | Action word for output B |
| irq_en | input | 6 | Per-event interrupt enables |
| trg_en | input | 6 | Per-event trigger enables |
| clr_stb | input | 1 | Status clear strobe |
| clr_mask | input | 6 | Status bits to clear when strobed |
| count | output | 16 | Current counter value |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| raw_stat | output | 6 | Sticky raw event status |
| irq | output | 1 | Masked interrupt |
| trig | output | 1 | One-cycle trigger pulse |

## Verification
The bench sets up cases where several events coincide:
- a compare value equal to the period value;
- a compare value of zero;
- both compares equal.

In these cases a wrong priority order drives the output to the wrong level. It also changes period and compare values in mid-period; a design without the zero-time sampling would cut the period short or move an edge early. In up/down mode it watches the turn at the peak and at zero, where a wrong direction flag would swap up and down compare actions. It also strobes clears on cycles when the same event fires, where a clear-wins design would lose a status bit.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

  localparam int NEV  = 6;
  localparam int ACTW = 2 * NEV;

  localparam int EV_ZERO = 0;
  localparam int EV_LOAD = 1;
  localparam int EV_AUP  = 2;
  localparam int EV_ADN  = 3;
  localparam int EV_BUP  = 4;
  localparam int EV_BDN  = 5;

  // Highest priority first.
  localparam int PRIO [NEV] = '{EV_BDN, EV_ADN, EV_BUP, EV_AUP, EV_LOAD, EV_ZERO};

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_FLIP = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_HIGH = 2'b11
  } act_e;

  // Select the code of the most important active event whose code is not KEEP.
  function automatic act_e pick_act(input logic [NEV-1:0] ev, input logic [ACTW-1:0] fld);
    act_e r;
    logic hit;
    r   = ACT_KEEP;
    hit = 1'b0;
    for (int k = 0; k < NEV; k++) begin
      if (!hit && ev[PRIO[k]] && (fld[2*PRIO[k] +: 2] != 2'b00)) begin
        r   = act_e'(fld[2*PRIO[k] +: 2]);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic apply_act(input act_e a, input logic cur);
    logic r;
    case (a)
      ACT_FLIP: r = ~cur;
      ACT_LOW:  r = 1'b0;
      ACT_HIGH: r = 1'b1;
      default:  r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwm_evt_counter.sv
module pwm_evt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          updown,
  input  logic [CW-1:0] load_in,
  input  logic [CW-1:0] cmpa_in,
  input  logic [CW-1:0] cmpb_in,
  output logic [CW-1:0] cnt,
  output logic          dir_up,
  output logic [CW-1:0] ld_act,
  output logic [CW-1:0] ca_act,
  output logic [CW-1:0] cb_act
);

  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic at_zero;
  logic at_peak;

  assign at_zero = (cnt == ZERO);
  assign at_peak = (cnt >= ld_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= ZERO;
      dir_up <= 1'b0;
      ld_act <= ZERO;
      ca_act <= ZERO;
      cb_act <= ZERO;
    end else if (run) begin
      if (at_zero) begin
        ld_act <= load_in;
        ca_act <= cmpa_in;
        cb_act <= cmpb_in;
        if (updown && (load_in != ZERO)) begin
          cnt    <= ONE;
          dir_up <= 1'b1;
        end else begin
          cnt    <= updown ? ZERO : load_in;
          dir_up <= 1'b0;
        end
      end else if (updown && dir_up && !at_peak) begin
        cnt    <= cnt + ONE;
        dir_up <= 1'b1;
      end else begin
        cnt    <= cnt - ONE;
        dir_up <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwm_evt_detect.sv
module pwm_evt_detect
  import pwm_evt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic           run,
  input  logic [CW-1:0]  cnt,
  input  logic           dir_up,
  input  logic [CW-1:0]  ld_act,
  input  logic [CW-1:0]  ca_act,
  input  logic [CW-1:0]  cb_act,
  output logic [NEV-1:0] ev
);

  logic hit_a;
  logic hit_b;
  logic is_zero;

  assign is_zero = (cnt == '0);
  assign hit_a   = (cnt == ca_act);
  assign hit_b   = (cnt == cb_act);

  always_comb begin
    ev          = '0;
    ev[EV_ZERO] = run && is_zero;
    ev[EV_LOAD] = run && !is_zero && (cnt == ld_act);
    ev[EV_AUP]  = run && hit_a && dir_up;
    ev[EV_ADN]  = run && hit_a && !dir_up;
    ev[EV_BUP]  = run && hit_b && dir_up;
    ev[EV_BDN]  = run && hit_b && !dir_up;
  end

endmodule

// File: rtl/pwm_evt_action.sv
module pwm_evt_action
  import pwm_evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEV-1:0]  ev,
  input  logic [ACTW-1:0] fld,
  output act_e            sel,
  output logic            pwm
);

  assign sel = pick_act(ev, fld);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm <= 1'b0;
    else        pwm <= apply_act(sel, pwm);
  end

endmodule

// File: rtl/pwm_evt_status.sv
module pwm_evt_status
  import pwm_evt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] ev,
  input  logic [NEV-1:0] irq_en,
  input  logic [NEV-1:0] trg_en,
  input  logic           clr_stb,
  input  logic [NEV-1:0] clr_mask,
  output logic [NEV-1:0] raw,
  output logic           irq,
  output logic           trig
);

  logic [NEV-1:0] clr_eff;

  assign clr_eff = clr_stb ? clr_mask : '0;
  assign irq     = |(raw & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw  <= '0;
      trig <= 1'b0;
    end else begin
      raw  <= (raw & ~clr_eff) | ev;
      trig <= |(ev & trg_en);
    end
  end

endmodule

// File: rtl/pwm_evt_gen.sv
module pwm_evt_gen
  import pwm_evt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            updown,
  input  logic [CW-1:0]   load_val,
  input  logic [CW-1:0]   cmpa_val,
  input  logic [CW-1:0]   cmpb_val,
  input  logic [ACTW-1:0] act_a,
  input  logic [ACTW-1:0] act_b,
  input  logic [NEV-1:0]  irq_en,
  input  logic [NEV-1:0]  trg_en,
  input  logic            clr_stb,
  input  logic [NEV-1:0]  clr_mask,
  output logic [CW-1:0]   count,
  output logic            pwm_a,
  output logic            pwm_b,
  output logic [NEV-1:0]  raw_stat,
  output logic            irq,
  output logic            trig
);

  localparam int NOUT = 2;

  logic [CW-1:0]   cnt_w;
  logic            dir_up_w;
  logic [CW-1:0]   ld_act_w;
  logic [CW-1:0]   ca_act_w;
  logic [CW-1:0]   cb_act_w;
  logic [NEV-1:0]  ev_w;
  logic [ACTW-1:0] fld_w [NOUT];
  act_e            sel_w [NOUT];
  logic [NOUT-1:0] pwm_w;

  assign fld_w[0] = act_a;
  assign fld_w[1] = act_b;

  pwm_evt_counter #(.CW(CW)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .updown  (updown),
    .load_in (load_val),
    .cmpa_in (cmpa_val),
    .cmpb_in (cmpb_val),
    .cnt     (cnt_w),
    .dir_up  (dir_up_w),
    .ld_act  (ld_act_w),
    .ca_act  (ca_act_w),
    .cb_act  (cb_act_w)
  );

  pwm_evt_detect #(.CW(CW)) u_detect (
    .run    (run),
    .cnt    (cnt_w),
    .dir_up (dir_up_w),
    .ld_act (ld_act_w),
    .ca_act (ca_act_w),
    .cb_act (cb_act_w),
    .ev     (ev_w)
  );

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    pwm_evt_action u_action (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev_w),
      .fld   (fld_w[g]),
      .sel   (sel_w[g]),
      .pwm   (pwm_w[g])
    );
  end

  pwm_evt_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev_w),
    .irq_en   (irq_en),
    .trg_en   (trg_en),
    .clr_stb  (clr_stb),
    .clr_mask (clr_mask),
    .raw      (raw_stat),
    .irq      (irq),
    .trig     (trig)
  );

  assign count = cnt_w;
  assign pwm_a = pwm_w[0];
  assign pwm_b = pwm_w[1];

endmodule

// File: rtl/pwm_evt_chk.sv
module pwm_evt_chk
  import pwm_evt_pkg::*;
#(
  parameter int CW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run,
  input logic           updown,
  input logic [CW-1:0]  load_val,
  input logic [CW-1:0]  count,
  input logic [NEV-1:0] ev,
  input logic [NEV-1:0] trg_en,
  input logic [NEV-1:0] raw_stat,
  input logic           trig,
  input logic           pwm_a,
  input logic           pwm_b
);

  // R2: a stopped counter keeps its value
  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count == $past(count));

  // R2: down-only mode reloads from the period input at zero
  a_r2_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !updown && count == '0) |=> count == $past(load_val));

  // R3: up/down mode moves by exactly one away from zero
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && updown && count != '0) |=>
      ((count == $past(count) + 1'b1) || (count == $past(count) - 1'b1)));

  // R11: no event while stopped
  a_r11_no_event_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> ev == '0);

  // R8: each occurring event leaves its status bit set
  a_r8_status_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((raw_stat & $past(ev)) == $past(ev)));

  // R10: a trigger pulse follows an enabled event
  a_r10_trig_cause: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past((ev & trg_en) != '0));

  // R6: outputs stay put on a cycle with no event
  a_r6_quiet_a: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == '0) |=> $stable(pwm_a));

  a_r6_quiet_b: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == '0) |=> $stable(pwm_b));

endmodule

bind pwm_evt_gen pwm_evt_chk #(.CW(CW)) u_pwm_evt_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .updown   (updown),
  .load_val (load_val),
  .count    (count),
  .ev       (ev_w),
  .trg_en   (trg_en),
  .raw_stat (raw_stat),
  .trig     (trig),
  .pwm_a    (pwm_a),
  .pwm_b    (pwm_b)
);

// File: tb/test_pwm_evt_gen.sv
module test_pwm_evt_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        updown = 1'b0;
  logic [15:0] load_val = '0;
  logic [15:0] cmpa_val = '0;
  logic [15:0] cmpb_val = '0;
  logic [11:0] act_a = '0;
  logic [11:0] act_b = '0;
  logic [5:0]  irq_en = '0;
  logic [5:0]  trg_en = '0;
  logic        clr_stb = 1'b0;
  logic [5:0]  clr_mask = '0;
  logic [15:0] count;
  logic        pwm_a, pwm_b, irq, trig;
  logic [5:0]  raw_stat;

  always #4 clk = ~clk;

  pwm_evt_gen i_pwm_evt_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .updown(updown),
    .load_val(load_val), .cmpa_val(cmpa_val), .cmpb_val(cmpb_val),
    .act_a(act_a), .act_b(act_b), .irq_en(irq_en), .trg_en(trg_en),
    .clr_stb(clr_stb), .clr_mask(clr_mask), .count(count),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .raw_stat(raw_stat), .irq(irq), .trig(trig)
  );

  typedef struct {
    logic [15:0] cnt;
    logic        pa, pb;
    logic [5:0]  raw;
    logic        irq, trig;
  } exp_t;

  exp_t  q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R1";
  bit    done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Reference model, written from the requirements.
  logic [15:0] m_cnt, m_ld, m_ca, m_cb;
  logic        m_up, m_pa, m_pb, m_trig;
  logic [5:0]  m_raw;

  function automatic logic resolve(input logic [5:0] e, input logic [11:0] a, input logic cur);
    logic [1:0] code;
    code = 2'b00;
    if      (e[5] && a[11:10] != 2'b00) code = a[11:10];
    else if (e[3] && a[7:6]   != 2'b00) code = a[7:6];
    else if (e[4] && a[9:8]   != 2'b00) code = a[9:8];
    else if (e[2] && a[5:4]   != 2'b00) code = a[5:4];
    else if (e[1] && a[3:2]   != 2'b00) code = a[3:2];
    else if (e[0])                      code = a[1:0];
    if (code == 2'b01) return !cur;
    if (code == 2'b10) return 1'b0;
    if (code == 2'b11) return 1'b1;
    return cur;
  endfunction

  always @(posedge clk) begin
    logic [5:0] e;
    exp_t x;
    if (!rst_n) begin
      m_cnt = 0; m_ld = 0; m_ca = 0; m_cb = 0;
      m_up = 0; m_pa = 0; m_pb = 0; m_trig = 0; m_raw = 0;
    end else begin
      e = 6'b0;
      if (run) begin
        e[0] = (m_cnt == 0);
        e[1] = (m_cnt != 0) && (m_cnt == m_ld);
        e[2] = (m_cnt == m_ca) && m_up;
        e[3] = (m_cnt == m_ca) && !m_up;
        e[4] = (m_cnt == m_cb) && m_up;
        e[5] = (m_cnt == m_cb) && !m_up;
      end
      m_pa   = resolve(e, act_a, m_pa);
      m_pb   = resolve(e, act_b, m_pb);
      m_raw  = (m_raw & ~(clr_stb ? clr_mask : 6'b0)) | e;
      m_trig = |(e & trg_en);
      if (run) begin
        if (m_cnt == 0) begin
          m_ld = load_val; m_ca = cmpa_val; m_cb = cmpb_val;
          if (!updown) begin m_cnt = load_val; m_up = 0; end
          else if (load_val == 0) begin m_cnt = 0; m_up = 0; end
          else begin m_cnt = 1; m_up = 1; end
        end else if (updown && m_up && m_cnt != m_ld) begin
          m_cnt = m_cnt + 1;
        end else begin
          m_cnt = m_cnt - 1; m_up = 0;
        end
      end
    end
    x.cnt = m_cnt; x.pa = m_pa; x.pb = m_pb; x.raw = m_raw;
    x.irq = |(m_raw & irq_en); x.trig = m_trig;
    q.push_back(x);
  end

  // Monitor: compares the outputs half a cycle after each edge.
  always @(negedge clk) begin
    exp_t x;
    if (!done && q.size() > 0) begin
      x = q.pop_front();
      chk({phase, " R2/R3"}, "count", 32'(count), 32'(x.cnt));
      chk({phase, " R6"}, "pwm_a", 32'(pwm_a), 32'(x.pa));
      chk({phase, " R6"}, "pwm_b", 32'(pwm_b), 32'(x.pb));
      chk({phase, " R8"}, "raw_stat", 32'(raw_stat), 32'(x.raw));
      chk({phase, " R9"}, "irq", 32'(irq), 32'(x.irq));
      chk({phase, " R10"}, "trig", 32'(trig), 32'(x.trig));
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_clear(input logic [5:0] m);
    clr_stb = 1'b1; clr_mask = m;
    cycles(1);
    clr_stb = 1'b0; clr_mask = 6'h0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      finish_up();
    end
  end

  initial begin
    run = 1'b1;
    cycles(3);
    // R1: outputs are clear while reset is held, even with run high
    chk("R1", "count", 32'(count), 0);
    chk("R1", "pwm", 32'({pwm_a, pwm_b}), 0);
    chk("R1", "raw/irq/trig", 32'({raw_stat, irq, trig}), 0);
    run = 1'b0;
    rst_n = 1'b1;
    cycles(2);

    phase = "R2";
    load_val = 16'd7; cmpa_val = 16'd3; cmpb_val = 16'd5;
    act_a = 12'h083; act_b = 12'h400;
    irq_en = 6'h3F; trg_en = 6'h01; run = 1'b1;
    cycles(40);

    phase = "R11";
    run = 1'b0;
    cycles(10);
    pulse_clear(6'h3F);
    cycles(5);

    phase = "R8";
    run = 1'b1;
    cycles(7);
    pulse_clear(6'h3F);
    cycles(3);
    pulse_clear(6'h05);
    cycles(4);

    phase = "R9";
    irq_en = 6'h04;
    pulse_clear(6'h3F);
    cycles(20);
    irq_en = 6'h00;
    cycles(5);

    phase = "R4";
    cycles(3);
    load_val = 16'd12; cmpa_val = 16'd10; cmpb_val = 16'd1;
    cycles(40);

    phase = "R3";
    updown = 1'b1; load_val = 16'd6; cmpa_val = 16'd2; cmpb_val = 16'd4;
    act_a = 12'h0B0; act_b = 12'hE00;
    irq_en = 6'h3F; trg_en = 6'h06;
    cycles(60);

    phase = "R5";
    cmpa_val = 16'd0; cmpb_val = 16'd6; act_a = 12'h555; act_b = 12'hAFF;
    trg_en = 6'h3F;
    cycles(40);

    phase = "R7";
    updown = 1'b0; load_val = 16'd4; cmpa_val = 16'd4; cmpb_val = 16'd4;
    act_a = 12'h08F; act_b = 12'h04C;
    cycles(30);
    updown = 1'b1; act_a = 12'h33C; act_b = 12'h10F;
    cycles(30);

    phase = "R6";
    updown = 1'b0; load_val = 16'd0; act_a = 12'h001; act_b = 12'h002;
    cycles(12);

    phase = "R10";
    for (int i = 0; i < 40; i++) begin
      logic [31:0] r;
      r = $urandom();
      updown   = r[0];
      load_val = 16'(r[5:1]);
      cmpa_val = 16'(r[10:6]);
      cmpb_val = 16'(r[15:11]);
      act_a    = r[27:16];
      act_b    = 12'($urandom());
      irq_en   = 6'($urandom());
      trg_en   = 6'($urandom());
      run      = (r[31:29] != 3'b000);
      cycles(45);
      if (r[28]) pulse_clear(6'($urandom()));
    end

    cycles(3);
    finish_up();
  end

endmodule